// File: doc/BRIEF.md
# Virtual Address Segment Translator

This block takes one 32-bit virtual address per request and works out where it lands. The top bits of the address pick one of five fixed regions. The low half of the space is for user code. Above it sit two kernel windows that are mapped directly and a mapped kernel area. An address in a direct window is turned into a physical address by removing a fixed base. An address in a mapped region is passed to an external page-table lookup unit (TLB), and the reply from that unit is turned into the final outcome. A user-mode access to the upper half is rejected at once with an address error. While the error-level flag is set and the core is in kernel mode, the lower half maps one-to-one onto physical memory.

Every accepted request produces exactly one result: a 3-bit outcome code, a physical address and read and write permissions. A direct or rejected access gives its result one cycle after the request. A mapped access gives its result one cycle after the TLB replies. Any result that is not a success also records the faulting address. It also forms a new entry-high word: the upper 20 bits come from the faulting address and the lower 12 bits are kept from the current value.

Top module: `vaddr_seg_xlate`

## Requirements
- R1: In user mode (`user_mode`=1), a request whose bit 31 is set gives outcome 1 (address error), with zero permissions and zero address. No TLB request is raised, and the result is due one cycle after the request.
- R2: In kernel mode with `err_level`=1, an address below 0x8000_0000 gives outcome 0 with a physical address equal to the virtual address, one cycle after the request.
- R3: An address below 0x8000_0000 in user mode (either `err_level`), or in kernel mode with `err_level`=0, raises `tlb_req_valid` in the request cycle, carrying the address and the write flag.
- R4: An address from 0x8000_0000 to 0x9FFF_FFFF gives physical address = virtual address minus 0x8000_0000, one cycle after the request.
- R5: An address from 0xA000_0000 to 0xBFFF_FFFF gives physical address = virtual address minus 0xA000_0000, one cycle after the request.
- R6: In kernel mode, an address at or above 0xC000_0000 raises a TLB request in the request cycle.
- R7: Every result from a directly mapped region has outcome 0 with `res_rd_ok`=1 and `res_wr_ok`=1.
- R8: The TLB reply code is 0 hit, 1 miss, 2 invalid or 3 write to a clean page. It maps to outcome 0, 2, 3 or 4, and the result is due one cycle after `tlb_rsp_valid`. On a hit, the address is taken from `tlb_rsp_paddr`, `res_rd_ok`=1 and `res_wr_ok` equals `tlb_rsp_dirty`. Otherwise the address and both permissions are 0.
- R9: While a TLB reply is outstanding, new requests are ignored: they raise no TLB request and give no result.
- R10: With every non-zero outcome, `bad_vaddr` takes the request address. `fault_entryhi` takes the upper 20 bits of that address, with `entryhi_keep` as its lower 12 bits. A zero outcome leaves both registers unchanged, and both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| user_mode | input | 1 | Core is in user mode |
| err_level | input | 1 | Error-level flag |
| entryhi_keep | input | 12 | Current low 12 bits of entry-high |
| tlb_req_valid | output | 1 | Lookup request to TLB |
| tlb_req_vaddr | output | 32 | Address for lookup |
| tlb_req_write | output | 1 | Lookup is for a store |
| tlb_rsp_valid | input | 1 | TLB reply strobe |
| tlb_rsp_code | input | 2 | 0 hit, 1 miss, 2 invalid, 3 clean-page write |
| tlb_rsp_paddr | input | 32 | Physical address on hit |
| tlb_rsp_dirty | input | 1 | Page is writable |
| res_valid | output | 1 | Result strobe |
| res_status | output | 3 | 0 ok, 1 address error, 2 miss, 3 invalid, 4 modified |
| res_paddr | output | 32 | Physical address |
| res_rd_ok | output | 1 | Read allowed |
| res_wr_ok | output | 1 | Write allowed |
| bad_vaddr | output | 32 | Last faulting address |
| fault_entryhi | output | 32 | Merged entry-high on last fault |

## Verification
A direct or rejected request has its result registered at the first rising edge after the request cycle. A mapped request shows `tlb_req_valid` within the request cycle itself, and its result follows the edge after the reply. The bench drives on falling edges and checks the TLB request just after driving it. It compares every result strobe with a queue of expected outcomes at the next falling edge, so a result that comes early, late or unasked for is seen. After each access the bench confirms that its queue has drained. The fault registers are compared with the model each time a result appears.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_ADDR_ERR  = 3'd1,
    ST_TLB_MISS  = 3'd2,
    ST_TLB_INVAL = 3'd3,
    ST_TLB_MOD   = 3'd4
  } xlate_st_e;

  typedef enum logic [1:0] {
    TR_HIT   = 2'd0,
    TR_MISS  = 2'd1,
    TR_INVAL = 2'd2,
    TR_MOD   = 2'd3
  } tlb_rc_e;
endpackage

// File: rtl/segx_classify.sv
module segx_classify #(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] va,
  input  logic            user_mode,
  input  logic            err_level,
  output logic            adr_err,
  output logic            use_tlb,
  output logic [VA_W-1:0] direct_pa
);
  localparam logic [VA_W-1:0] K0_BASE = {3'b100, {(VA_W-3){1'b0}}};
  localparam logic [VA_W-1:0] K1_BASE = {3'b101, {(VA_W-3){1'b0}}};

  logic [2:0] seg_sel;
  assign seg_sel = va[VA_W-1 -: 3];

  always_comb begin
    adr_err   = 1'b0;
    use_tlb   = 1'b0;
    direct_pa = '0;
    if (user_mode && va[VA_W-1]) begin
      adr_err = 1'b1;
    end else if (!va[VA_W-1]) begin
      if (!user_mode && err_level) direct_pa = va;
      else                         use_tlb   = 1'b1;
    end else if (seg_sel == 3'b100) begin
      direct_pa = va - K0_BASE;
    end else if (seg_sel == 3'b101) begin
      direct_pa = va - K1_BASE;
    end else begin
      use_tlb = 1'b1;
    end
  end
endmodule

// File: rtl/segx_merge.sv
module segx_merge
  import segx_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [VA_W-1:0] take_va,
  input  logic            adr_err,
  input  logic            use_tlb,
  input  logic [VA_W-1:0] direct_pa,
  input  logic            tlb_rsp_valid,
  input  logic [1:0]      tlb_rsp_code,
  input  logic [VA_W-1:0] tlb_rsp_paddr,
  input  logic            tlb_rsp_dirty,
  output logic            pending,
  output logic            fault_fire,
  output logic [VA_W-1:0] fault_va,
  output logic            res_valid,
  output logic [2:0]      res_status,
  output logic [VA_W-1:0] res_paddr,
  output logic            res_rd_ok,
  output logic            res_wr_ok
);
  logic            pend_q, pend_d;
  logic [VA_W-1:0] va_q, va_d;
  logic            vld_q, vld_d;
  xlate_st_e       st_q, st_d;
  logic [VA_W-1:0] pa_q, pa_d;
  logic            rd_q, rd_d, wr_q, wr_d;
  logic            out_en;

  always_comb begin
    pend_d = pend_q;
    va_d   = va_q;
    vld_d  = 1'b0;
    st_d   = st_q;
    pa_d   = pa_q;
    rd_d   = rd_q;
    wr_d   = wr_q;
    out_en = 1'b0;
    if (take) begin
      va_d = take_va;
      if (adr_err) begin
        vld_d = 1'b1; out_en = 1'b1;
        st_d = ST_ADDR_ERR; pa_d = '0; rd_d = 1'b0; wr_d = 1'b0;
      end else if (use_tlb) begin
        pend_d = 1'b1;
      end else begin
        vld_d = 1'b1; out_en = 1'b1;
        st_d = ST_OK; pa_d = direct_pa; rd_d = 1'b1; wr_d = 1'b1;
      end
    end else if (pend_q && tlb_rsp_valid) begin
      pend_d = 1'b0;
      vld_d  = 1'b1;
      out_en = 1'b1;
      pa_d   = '0;
      rd_d   = 1'b0;
      wr_d   = 1'b0;
      case (tlb_rc_e'(tlb_rsp_code))
        TR_HIT: begin
          st_d = ST_OK; pa_d = tlb_rsp_paddr; rd_d = 1'b1; wr_d = tlb_rsp_dirty;
        end
        TR_MISS:  st_d = ST_TLB_MISS;
        TR_INVAL: st_d = ST_TLB_INVAL;
        default:  st_d = ST_TLB_MOD;
      endcase
    end
  end

  assign fault_fire = vld_d && (st_d != ST_OK);
  assign fault_va   = va_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      va_q   <= '0;
      vld_q  <= 1'b0;
      st_q   <= ST_OK;
      pa_q   <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      va_q   <= va_d;
      vld_q  <= vld_d;
      if (out_en) begin
        st_q <= st_d;
        pa_q <= pa_d;
        rd_q <= rd_d;
        wr_q <= wr_d;
      end
    end
  end

  assign pending    = pend_q;
  assign res_valid  = vld_q;
  assign res_status = st_q;
  assign res_paddr  = pa_q;
  assign res_rd_ok  = rd_q;
  assign res_wr_ok  = wr_q;

  // R8: a reply while waiting completes the access at the next edge
  a_r8_reply_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tlb_rsp_valid) |=> (res_valid && !pending));

  // R7: a direct-window result always grants both permissions
  a_r7_direct_perm: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !adr_err && !use_tlb) |=> (res_valid && res_rd_ok && res_wr_ok && res_status == 3'd0));
endmodule

// File: rtl/segx_fault_cap.sv
module segx_fault_cap #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [VA_W-1:0]      va,
  input  logic [PAGE_BITS-1:0] keep_low,
  output logic [VA_W-1:0]      bad_vaddr,
  output logic [VA_W-1:0]      fault_entryhi
);
  logic [VA_W-1:0] bva_q, bva_d, ehi_q, ehi_d;

  always_comb begin
    bva_d = bva_q;
    ehi_d = ehi_q;
    if (fire) begin
      bva_d = va;
      ehi_d = {va[VA_W-1:PAGE_BITS], keep_low};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bva_q <= '0;
      ehi_q <= '0;
    end else if (fire) begin
      bva_q <= bva_d;
      ehi_q <= ehi_d;
    end
  end

  assign bad_vaddr     = bva_q;
  assign fault_entryhi = ehi_q;
endmodule

// File: rtl/vaddr_seg_xlate.sv
module vaddr_seg_xlate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic                 req_write,
  input  logic                 user_mode,
  input  logic                 err_level,
  input  logic [PAGE_BITS-1:0] entryhi_keep,
  output logic                 tlb_req_valid,
  output logic [VA_W-1:0]      tlb_req_vaddr,
  output logic                 tlb_req_write,
  input  logic                 tlb_rsp_valid,
  input  logic [1:0]           tlb_rsp_code,
  input  logic [VA_W-1:0]      tlb_rsp_paddr,
  input  logic                 tlb_rsp_dirty,
  output logic                 res_valid,
  output logic [2:0]           res_status,
  output logic [VA_W-1:0]      res_paddr,
  output logic                 res_rd_ok,
  output logic                 res_wr_ok,
  output logic [VA_W-1:0]      bad_vaddr,
  output logic [VA_W-1:0]      fault_entryhi
);
  logic            adr_err, use_tlb, pending, take, fault_fire;
  logic [VA_W-1:0] direct_pa, fault_va;

  segx_classify #(.VA_W(VA_W)) u_classify (
    .va(req_vaddr), .user_mode(user_mode), .err_level(err_level),
    .adr_err(adr_err), .use_tlb(use_tlb), .direct_pa(direct_pa)
  );

  assign take          = req_valid && !pending;
  assign tlb_req_valid = take && use_tlb && !adr_err;
  assign tlb_req_vaddr = req_vaddr;
  assign tlb_req_write = req_write;

  segx_merge #(.VA_W(VA_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .take(take), .take_va(req_vaddr),
    .adr_err(adr_err), .use_tlb(use_tlb), .direct_pa(direct_pa),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code),
    .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_dirty(tlb_rsp_dirty),
    .pending(pending), .fault_fire(fault_fire), .fault_va(fault_va),
    .res_valid(res_valid), .res_status(res_status), .res_paddr(res_paddr),
    .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok)
  );

  segx_fault_cap #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_fault (
    .clk(clk), .rst_n(rst_n), .fire(fault_fire), .va(fault_va),
    .keep_low(entryhi_keep), .bad_vaddr(bad_vaddr), .fault_entryhi(fault_entryhi)
  );

  // R1: user access to the upper half is rejected on the next edge
  a_r1_user_high_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pending && user_mode && req_vaddr[VA_W-1]) |=> (res_valid && res_status == 3'd1));

  // R4: lower kernel window strips its base
  a_r4_kwin0_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pending && !user_mode && req_vaddr[VA_W-1 -: 3] == 3'b100)
    |=> (res_valid && res_paddr == {1'b0, $past(req_vaddr[VA_W-2:0])}));

  // R9: no second lookup while one is outstanding
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !tlb_req_valid);

  // R10: the captured page numbers agree after any fault
  a_r10_capture_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status != 3'd0) |-> (bad_vaddr[VA_W-1:PAGE_BITS] == fault_entryhi[VA_W-1:PAGE_BITS]));
endmodule

// File: tb/test_vaddr_seg_xlate.sv
module test_vaddr_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        user_mode = 1'b0;
  logic        err_level = 1'b0;
  logic [11:0] entryhi_keep = 12'h0A5;
  logic        tlb_req_valid, tlb_req_write;
  logic [31:0] tlb_req_vaddr;
  logic        tlb_rsp_valid = 1'b0;
  logic [1:0]  tlb_rsp_code = '0;
  logic [31:0] tlb_rsp_paddr = '0;
  logic        tlb_rsp_dirty = 1'b0;
  logic        res_valid, res_rd_ok, res_wr_ok;
  logic [2:0]  res_status;
  logic [31:0] res_paddr, bad_vaddr, fault_entryhi;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [2:0]  st;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    logic [31:0] va;
    string       tag;
  } exp_t;
  exp_t        expq[$];
  logic [31:0] exp_bva = '0;
  logic [31:0] exp_ehi = '0;

  always #4 clk = ~clk;

  vaddr_seg_xlate i_vaddr_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .user_mode(user_mode), .err_level(err_level),
    .entryhi_keep(entryhi_keep), .tlb_req_valid(tlb_req_valid),
    .tlb_req_vaddr(tlb_req_vaddr), .tlb_req_write(tlb_req_write),
    .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_code(tlb_rsp_code),
    .tlb_rsp_paddr(tlb_rsp_paddr), .tlb_rsp_dirty(tlb_rsp_dirty),
    .res_valid(res_valid), .res_status(res_status), .res_paddr(res_paddr),
    .res_rd_ok(res_rd_ok), .res_wr_ok(res_wr_ok), .bad_vaddr(bad_vaddr),
    .fault_entryhi(fault_entryhi)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // result monitor: compared on every falling edge
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected result", {29'd0, res_status}, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(res_status == e.st, {e.tag, " status"}, {29'd0, res_status}, {29'd0, e.st});
        chk(res_paddr == e.pa, {e.tag, " paddr"}, res_paddr, e.pa);
        chk({res_rd_ok, res_wr_ok} == {e.rd, e.wr}, {e.tag, " perm"},
            {30'd0, res_rd_ok, res_wr_ok}, {30'd0, e.rd, e.wr});
        if (e.st != 3'd0) begin
          exp_bva = e.va;
          exp_ehi = {e.va[31:12], entryhi_keep};
        end
        chk(bad_vaddr == exp_bva, "R10 bad_vaddr", bad_vaddr, exp_bva);
        chk(fault_entryhi == exp_ehi, "R10 entryhi", fault_entryhi, exp_ehi);
      end
    end
  end

  // one access; code/tpa/dirty used only when the address is mapped
  task automatic access(input logic [31:0] va, input logic wr, input logic um, input logic erl,
                        input logic [1:0] code, input logic [31:0] tpa, input logic dirty,
                        input logic poke_busy, input string tag);
    exp_t e;
    logic need;
    need = 1'b0;
    e.va = va; e.tag = tag; e.pa = '0; e.rd = 1'b0; e.wr = 1'b0; e.st = 3'd0;
    if (um && va[31]) e.st = 3'd1;
    else if (!va[31]) begin
      if (!um && erl) begin e.pa = va; e.rd = 1'b1; e.wr = 1'b1; end
      else need = 1'b1;
    end else if (va[31:29] == 3'b100) begin e.pa = va - 32'h8000_0000; e.rd = 1'b1; e.wr = 1'b1; end
    else if (va[31:29] == 3'b101) begin e.pa = va - 32'hA000_0000; e.rd = 1'b1; e.wr = 1'b1; end
    else need = 1'b1;
    if (need) begin
      case (code)
        2'd0: begin e.st = 3'd0; e.pa = tpa; e.rd = 1'b1; e.wr = dirty; end
        2'd1: e.st = 3'd2;
        2'd2: e.st = 3'd3;
        default: e.st = 3'd4;
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; user_mode = um; err_level = erl;
    #1;
    chk(tlb_req_valid == need, {tag, " tlb_req_valid"}, {31'd0, tlb_req_valid}, {31'd0, need});
    if (need) begin
      chk(tlb_req_vaddr == va && tlb_req_write == wr, {tag, " R3 tlb_req fields"}, tlb_req_vaddr, va);
    end else begin
      expq.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (need) begin
      if (poke_busy) begin
        req_valid = 1'b1; req_vaddr = 32'h8000_1234; user_mode = 1'b0;
        #1;
        chk(tlb_req_valid == 1'b0, "R9 no lookup while waiting", {31'd0, tlb_req_valid}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
      end
      tlb_rsp_valid = 1'b1; tlb_rsp_code = code; tlb_rsp_paddr = tpa; tlb_rsp_dirty = dirty;
      expq.push_back(e);
      @(negedge clk);
      tlb_rsp_valid = 1'b0;
    end
    #1;
    chk(expq.size() == 0, {tag, " result on time"}, expq.size(), 32'd0);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(res_valid == 1'b0 && tlb_req_valid == 1'b0, "reset outputs idle", {31'd0, res_valid}, 32'd0);
    chk(bad_vaddr == 32'd0 && fault_entryhi == 32'd0, "R10 reset capture", bad_vaddr, 32'd0);
    rst_n = 1'b1;
    // R1 user upper half
    access(32'h8000_0040, 1'b0, 1'b1, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, "R1 user kwin0");
    access(32'hF123_4567, 1'b1, 1'b1, 1'b1, 2'd0, 32'd0, 1'b0, 1'b0, "R1 user top");
    // R2 error-level identity
    access(32'h1234_5678, 1'b1, 1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 1'b0, "R2 identity");
    access(32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 1'b0, "R2 identity edge");
    // R4 / R5 / R7 direct windows and their edges
    access(32'h8000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, "R4 R7 kwin0 low");
    access(32'h9FFF_FFFF, 1'b1, 1'b0, 1'b1, 2'd0, 32'd0, 1'b0, 1'b0, "R4 R7 kwin0 high");
    access(32'hA000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, "R5 R7 kwin1 low");
    access(32'hBFFF_F00C, 1'b1, 1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, "R5 R7 kwin1 high");
    // R3 / R8 mapped low half, each reply code
    access(32'h0040_1000, 1'b0, 1'b1, 1'b0, 2'd0, 32'h0123_4000, 1'b1, 1'b0, "R3 R8 hit dirty");
    access(32'h0040_2000, 1'b1, 1'b1, 1'b1, 2'd0, 32'h0555_6000, 1'b0, 1'b0, "R3 R8 hit clean");
    entryhi_keep = 12'h3C7;
    access(32'h7FFF_E123, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_0000, 1'b0, 1'b0, "R3 R8 miss");
    // R6 / R8 upper mapped area
    access(32'hC000_0000, 1'b0, 1'b0, 1'b1, 2'd2, 32'h0000_0000, 1'b0, 1'b0, "R6 R8 invalid");
    entryhi_keep = 12'hFFF;
    access(32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 2'd3, 32'h0000_0000, 1'b0, 1'b0, "R6 R8 modified");
    // R9 request while waiting is dropped
    access(32'hE000_8000, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0ABC_D000, 1'b1, 1'b1, "R9 R6 busy");
    // R10 an ok result leaves the capture untouched
    access(32'h8765_4321, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0, "R10 ok keeps capture");
    repeat (3) @(negedge clk);
    #1;
    chk(expq.size() == 0, "R9 no stray results", expq.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule